// File: doc/BRIEF.md
# Serial Synthesizer Control Word Receiver

This block receives a 40-bit control word for a numerically controlled oscillator over a three-wire serial link. The link has a word clock, a data line and an update strobe. All three lines are asynchronous to the block. They are first brought into the system clock domain through a synchronizer bank, and the word clock and the strobe are then edge-detected. The data line is sampled on each rising edge of the word clock and shifted into a staging register. The first bit received is the least significant bit of the word.

A rising edge of the update strobe copies the staging register into an active register. The same edge returns the bit pointer to zero, so the next word starts fresh. The active register is split into four outputs: a 32-bit tuning word, a 2-bit mode, a power-down flag and a 5-bit phase offset. Normal operation uses mode 00, and a typical word has its upper eight bits clear.

Bit counting is handled by a four-state machine:
- **Four states:**
  - ST_EMPTY: no bits received since the last update or reset.
  - ST_FILLING: 1 to 39 bits received.
  - ST_READY: exactly 40 bits received.
  - ST_OVERRUN: more than 40 bits received.
- **Transitions:**
  - *shift_first* goes from ST_EMPTY to ST_FILLING.
  - *shift_more* keeps ST_FILLING.
  - *shift_last* goes from ST_FILLING to ST_READY on the fortieth bit.
  - *shift_extra* goes from ST_READY, or stays in ST_OVERRUN, on any further bit.
  - *update* goes from any state to ST_EMPTY.

If a strobe edge and a word-clock edge are detected in the same cycle, the update wins and that bit is dropped.

Top module: `dds_word_loader`

## Requirements
- R1: After reset the tuning word, phase, mode and power-down outputs are all zero and the ready flag is low.
- R2: Each rising word-clock edge samples the data line. Bits are taken least significant first, so the first of 40 bits becomes bit 0 of the loaded word.
- R3: The loaded word is split as follows: bits 31:0 form the tuning word, bits 33:32 the mode, bit 34 the power-down flag, and bits 39:35 the phase.
- R4: The outputs change only on a rising strobe edge. Shifting bits in, or holding the strobe high, leaves them unchanged.
- R5: A rising strobe edge copies the full 40-bit staging contents into the active register.
- R6: A rising strobe edge resets the bit pointer. After a partial word and an update, the ready flag rises on exactly the fortieth bit of the next word.
- R7: The ready flag is high only when exactly 40 bits have arrived since the last update or reset.
- R8: Word-clock edges beyond the fortieth push out the earliest bits. After 41 bits, the loaded word is the last 40 bits and the ready flag is low.
- R9: A strobe while the ready flag is low still loads the staging contents. After reset and 5 bits, those bits appear as the phase field, first bit in phase bit 0, with all other fields zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wclk_i | input | 1 | Serial word clock, asynchronous |
| sdata_i | input | 1 | Serial data line, asynchronous |
| upd_i | input | 1 | Update strobe, asynchronous |
| tuning_o | output | 32 | Active tuning word |
| phase_o | output | 5 | Active phase offset |
| pdown_o | output | 1 | Active power-down flag |
| mode_o | output | 2 | Active mode select |
| ready_o | output | 1 | Exactly 40 bits staged |

## Verification
The assertions assume the following about the serial lines:
- Every high and low level of the word clock and the strobe lasts longer than the synchronizer depth plus one system cycle, so each edge yields one single-cycle pulse.
- The data line is already settled when the word clock rises, because both pass through synchronizers of equal depth.
- A strobe edge never coincides with a word-clock edge.

The stimulus holds every level for four system cycles. It changes data two cycles before raising the word clock, and it never moves the strobe while a bit is in flight.

// File: rtl/dds_load_pkg.sv
package dds_load_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_FILLING = 2'd1,
        ST_READY   = 2'd2,
        ST_OVERRUN = 2'd3
    } fill_state_e;
endpackage

// File: rtl/dds_sync_bank.sv
module dds_sync_bank #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= async_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[s] <= '0;
            else     stg[s] <= stg[s-1];
        end
    end

    assign sync_o = stg[STAGES-1];
endmodule

// File: rtl/dds_rise_detect.sv
module dds_rise_detect #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] lvl_i,
    output logic [WIDTH-1:0] rise_o
);
    logic [WIDTH-1:0] dly;

    always_ff @(posedge clk) begin
        if (rst) dly <= '0;
        else     dly <= lvl_i;
    end

    assign rise_o = lvl_i & ~dly;

    for (genvar i = 0; i < WIDTH; i++) begin : g_chk
        // R2: one edge of a serial line gives a single-cycle pulse
        p_single_pulse_r2: assert property (@(posedge clk) disable iff (rst)
            rise_o[i] |=> !rise_o[i]);
    end
endmodule

// File: rtl/dds_shift_ctrl.sv
module dds_shift_ctrl
    import dds_load_pkg::*;
#(
    parameter int WORD_W = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic              load_en,
    input  logic              din,
    output logic [WORD_W-1:0] word_o,
    output logic              ready_o
);
    localparam int CNT_W = $clog2(WORD_W + 2);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] SAT_CNT  = CNT_W'(WORD_W + 1);

    fill_state_e       state, nxt;
    logic [CNT_W-1:0]  cnt;
    logic [WORD_W-1:0] sr;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_EMPTY;
        else     state <= nxt;
    end

    // transitions: update wins over a coincident shift
    always_comb begin
        nxt = state;
        if (load_en) begin
            nxt = ST_EMPTY;
        end else if (shift_en) begin
            unique case (state)
                ST_EMPTY:   nxt = ST_FILLING;
                ST_FILLING: nxt = (cnt == LAST_IDX) ? ST_READY : ST_FILLING;
                ST_READY:   nxt = ST_OVERRUN;
                ST_OVERRUN: nxt = ST_OVERRUN;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_READY: ready_o = 1'b1;
            default:  ready_o = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || load_en)                   cnt <= '0;
        else if (shift_en && cnt != SAT_CNT)  cnt <= cnt + 1'b1;
    end

    // newest bit enters at the top, so the first bit ends at bit 0
    always_ff @(posedge clk) begin
        if (rst)                       sr <= '0;
        else if (shift_en && !load_en) sr <= {din, sr[WORD_W-1:1]};
    end

    assign word_o = sr;

    p_ptr_reset_r6: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (cnt == '0 && state == ST_EMPTY));
    p_ready_exact_r7: assert property (@(posedge clk) disable iff (rst)
        ready_o |-> cnt == FULL_CNT);
    p_lsb_entry_r2: assert property (@(posedge clk) disable iff (rst)
        (shift_en && !load_en) |=> sr[WORD_W-1] == $past(din));
    p_push_out_r8: assert property (@(posedge clk) disable iff (rst)
        (shift_en && !load_en) |=> sr[WORD_W-2:0] == $past(sr[WORD_W-1:1]));
    p_hold_sr_r4: assert property (@(posedge clk) disable iff (rst)
        (!shift_en) |=> $stable(sr));
endmodule

// File: rtl/dds_ctrl_reg.sv
module dds_ctrl_reg #(
    parameter int FREQ_W  = 32,
    parameter int MODE_W  = 2,
    parameter int PHASE_W = 5
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              load_en,
    input  logic [FREQ_W+MODE_W+PHASE_W:0]    word_i,
    output logic [FREQ_W-1:0]                 tuning_o,
    output logic [MODE_W-1:0]                 mode_o,
    output logic                              pdown_o,
    output logic [PHASE_W-1:0]                phase_o
);
    localparam int WORD_W = FREQ_W + MODE_W + 1 + PHASE_W;
    localparam int PD_BIT = FREQ_W + MODE_W;

    logic [WORD_W-1:0] active;

    always_ff @(posedge clk) begin
        if (rst)          active <= '0;
        else if (load_en) active <= word_i;
    end

    assign tuning_o = active[FREQ_W-1:0];
    assign mode_o   = active[PD_BIT-1:FREQ_W];
    assign pdown_o  = active[PD_BIT];
    assign phase_o  = active[WORD_W-1:PD_BIT+1];

    p_load_copy_r5: assert property (@(posedge clk) disable iff (rst)
        load_en |=> active == $past(word_i));
    p_hold_active_r4: assert property (@(posedge clk) disable iff (rst)
        !load_en |=> $stable(active));
endmodule

// File: rtl/dds_word_loader.sv
module dds_word_loader #(
    parameter int FREQ_W      = 32,
    parameter int MODE_W      = 2,
    parameter int PHASE_W     = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wclk_i,
    input  logic               sdata_i,
    input  logic               upd_i,
    output logic [FREQ_W-1:0]  tuning_o,
    output logic [PHASE_W-1:0] phase_o,
    output logic               pdown_o,
    output logic [MODE_W-1:0]  mode_o,
    output logic               ready_o
);
    localparam int WORD_W = FREQ_W + MODE_W + 1 + PHASE_W;

    logic [2:0]        lines_s;
    logic [1:0]        rise;
    logic [WORD_W-1:0] staged;

    dds_sync_bank #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i ({sdata_i, upd_i, wclk_i}),
        .sync_o  (lines_s)
    );

    dds_rise_detect #(.WIDTH(2)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .lvl_i  (lines_s[1:0]),
        .rise_o (rise)
    );

    dds_shift_ctrl #(.WORD_W(WORD_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .shift_en (rise[0]),
        .load_en  (rise[1]),
        .din      (lines_s[2]),
        .word_o   (staged),
        .ready_o  (ready_o)
    );

    dds_ctrl_reg #(.FREQ_W(FREQ_W), .MODE_W(MODE_W), .PHASE_W(PHASE_W)) u_reg (
        .clk      (clk),
        .rst      (rst),
        .load_en  (rise[1]),
        .word_i   (staged),
        .tuning_o (tuning_o),
        .mode_o   (mode_o),
        .pdown_o  (pdown_o),
        .phase_o  (phase_o)
    );

    p_reset_clear_r1: assert property (@(posedge clk)
        $past(rst) |-> (tuning_o == '0 && phase_o == '0 && !pdown_o
                        && mode_o == '0 && !ready_o));
endmodule

// File: tb/tb_dds_word_loader.sv
`timescale 1ns/1ps
module tb_dds_word_loader;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wclk_i = 1'b0;
    logic        sdata_i = 1'b0;
    logic        upd_i = 1'b0;
    logic [31:0] tuning_o;
    logic [4:0]  phase_o;
    logic        pdown_o;
    logic [1:0]  mode_o;
    logic        ready_o;

    int n_run  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    dds_word_loader dut (
        .clk(clk), .rst(rst), .wclk_i(wclk_i), .sdata_i(sdata_i),
        .upd_i(upd_i), .tuning_o(tuning_o), .phase_o(phase_o),
        .pdown_o(pdown_o), .mode_o(mode_o), .ready_o(ready_o)
    );

    function automatic logic [39:0] mk(input logic [4:0] ph, input logic pd,
                                       input logic [1:0] md, input logic [31:0] tw);
        return {ph, pd, md, tw};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_word(input string req, input logic [39:0] w);
        check({req, " tuning"}, 64'(tuning_o), 64'(w[31:0]));
        check({req, " mode"},   64'(mode_o),   64'(w[33:32]));
        check({req, " pdown"},  64'(pdown_o),  64'(w[34]));
        check({req, " phase"},  64'(phase_o),  64'(w[39:35]));
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk) sdata_i = b;
        repeat (2) @(negedge clk);
        wclk_i = 1'b1;
        repeat (4) @(negedge clk);
        wclk_i = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic send_bits(input logic [39:0] v, input int n);
        for (int i = 0; i < n; i++) send_bit(v[i]);
    endtask

    task automatic pulse_upd();
        @(negedge clk) upd_i = 1'b1;
        repeat (4) @(negedge clk);
        upd_i = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        check_word("R1 reset", 40'h0);
        check("R1 ready", 64'(ready_o), 64'h0);
    endtask

    task automatic t_single_word();
        logic [39:0] w = mk(5'h15, 1'b1, 2'b10, 32'hDEADBEEF);
        send_bits(w, 40);
        check("R7 ready after 40", 64'(ready_o), 64'h1);
        check_word("R4 no change before update", 40'h0);
        pulse_upd();
        check_word("R2 R3 R5 loaded word", w);
        check("R6 ready cleared by update", 64'(ready_o), 64'h0);
    endtask

    task automatic t_pointer_reset();
        logic [39:0] w = mk(5'h0A, 1'b0, 2'b01, 32'h1234_5678);
        send_bits(40'hFFFF_FFFF_FF, 15);
        check("R7 ready low after 15", 64'(ready_o), 64'h0);
        pulse_upd();
        send_bits(w, 39);
        check("R6 ready low at 39", 64'(ready_o), 64'h0);
        send_bit(w[39]);
        check("R6 ready at 40th after update", 64'(ready_o), 64'h1);
        pulse_upd();
        check_word("R5 second word", w);
    endtask

    task automatic t_overrun();
        logic [39:0] w = mk(5'h03, 1'b0, 2'b00, 32'h0000_00A5);
        send_bit(1'b1);
        send_bits(w, 40);
        check("R8 ready low after 41", 64'(ready_o), 64'h0);
        pulse_upd();
        check_word("R8 last 40 bits kept", w);
    endtask

    task automatic t_partial();
        do_reset();
        check_word("R1 reset again", 40'h0);
        send_bits(40'h13, 5);
        check("R9 ready low partial", 64'(ready_o), 64'h0);
        pulse_upd();
        check_word("R9 partial load", mk(5'h13, 1'b0, 2'b00, 32'h0));
    endtask

    task automatic t_level_hold();
        logic [39:0] w = mk(5'h1F, 1'b1, 2'b11, 32'hCAFE_0001);
        send_bits(w, 40);
        pulse_upd();
        @(negedge clk) upd_i = 1'b1;
        repeat (6) @(negedge clk);
        send_bits(40'h0, 40);
        check_word("R4 strobe held high", w);
        upd_i = 1'b0;
        repeat (6) @(negedge clk);
        check_word("R4 strobe falling", w);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_single_word();
        t_pointer_reset();
        t_overrun();
        t_partial();
        t_level_hold();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule